// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is a 32-bit down-counting timer for one processor core. Software reaches it through a small register window with a synchronous read/write port. There are four registers: a reload value, the live count, a control word and an interrupt flag. While counting is enabled, the count drops by one every (divider + 1) clock cycles. The divider is an 8-bit field in the control word.

When the count steps from one to zero, the interrupt flag is set, and the single level-sensitive interrupt output follows that flag. In one-shot operation the count then stays at zero. In periodic operation the count is refilled from the reload register and keeps running. Software clears the flag by writing a one to it.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset the reload value, count, control word, interrupt flag and read data are all zero, and `irq` is low.
- R2: The word index is `addr[4:2]`. Index 0 is the reload register, 1 the count, 2 the control word and 3 the interrupt flag. Indices 4 to 7 read as zero, and writes to them change nothing. Address bits 1:0 are ignored.
- R3: In the control word, bit 0 enables counting, bit 1 selects periodic reload, and bits 15:8 hold the divider. A read returns these fields with all other bits zero.
- R4: While enabled with a nonzero count and no register write in that cycle, the count decrements once every (divider + 1) cycles. A write to the reload, count or control register restarts the divider phase, so the first decrement comes (divider + 1) cycles after the write. While disabled the count holds.
- R5: Writing the reload register sets both the reload value and the count. Writing the count register sets only the count.
- R6: When a decrement takes the count from 1 to 0, the interrupt flag is set. In one-shot mode the count then stays at zero. An enabled timer sitting at zero raises no further interrupts.
- R7: In periodic mode, the decrement that would reach zero instead loads the count from the reload register, and also sets the interrupt flag.
- R8: Writing to the flag register with data bit 0 set clears the flag. An expiry in the same cycle takes priority and leaves the flag set. `irq` always equals the flag.
- R9: A control write that turns the enable bit from 0 to 1, while the count is zero and the written reload bit is 1, copies the reload value into the count.
- R10: A read of the count register returns zero while counting is disabled. Otherwise it returns the live count.
- R11: A read returns, on the clock edge where `rd_en` is sampled, the register contents from before that edge. `rd_data` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the divider's time base |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address; bits 4:2 select the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt; equals the interrupt flag |

## Verification
A divider phase that is off by one cycle moves the edge where `irq` rises. The bench compares `irq` with its own model on every cycle, so the error shows up at the expiry that follows. A count register that is decremented wrongly, or not refilled, appears as a wrong value on the next read of the count. It also shifts every later interrupt, and the random reads of the count catch that within a few dozen cycles. A reload or enable-edge error leaves the count at zero or at a stale value, and the next count read shows it.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned IDX_LOAD = 0;
  localparam int unsigned IDX_CNT  = 1;
  localparam int unsigned IDX_CTRL = 2;
  localparam int unsigned IDX_FLAG = 3;

  typedef struct packed {
    logic [7:0] div;
    logic       periodic;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tick_timer_div.sv
module tick_timer_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  assign tick = active && (phase_q == div);

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      phase_q <= '0;
    end else if (phase_q == div) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic [CNT_W-1:0] set_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  assign count  = count_q;
  assign expire = tick && !set && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (set) begin
      count_q <= set_val;
    end else if (tick && count_q != '0) begin
      if (count_q == ONE) begin
        count_q <= periodic ? reload_val : '0;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end
endmodule

// File: rtl/tick_timer_rdmux.sv
module tick_timer_rdmux
  import tick_timer_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int CNT_W = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] count,
  input  ctrl_t            ctrl,
  input  logic             flag,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    case (idx)
      IDX_W'(IDX_LOAD): sel = DW'(reload_val);
      IDX_W'(IDX_CNT):  sel = ctrl.run ? DW'(count) : '0;
      IDX_W'(IDX_CTRL): sel = DW'({ctrl.div, 6'b0, ctrl.periodic, ctrl.run});
      IDX_W'(IDX_FLAG): sel = DW'(flag);
      default:          sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= sel;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int CNT_W = DW;

  logic [IDX_W-1:0] idx;
  logic             wr_load, wr_cnt, wr_ctrl, wr_flag, run_rise;
  logic             cnt_set, restart, active, tick, expire;
  logic [CNT_W-1:0] cnt_set_val, count_q, reload_q;
  ctrl_t            ctrl_q;
  logic             flag_q;

  assign idx     = addr[ADDR_W-1:2];
  assign wr_load = wr_en && (idx == IDX_W'(IDX_LOAD));
  assign wr_cnt  = wr_en && (idx == IDX_W'(IDX_CNT));
  assign wr_ctrl = wr_en && (idx == IDX_W'(IDX_CTRL));
  assign wr_flag = wr_en && (idx == IDX_W'(IDX_FLAG));

  assign run_rise = wr_ctrl && wr_data[0] && !ctrl_q.run;
  assign restart  = wr_load || wr_cnt || wr_ctrl;
  assign active   = ctrl_q.run && (count_q != '0) && !restart;

  always_comb begin
    cnt_set     = 1'b0;
    cnt_set_val = wr_data[CNT_W-1:0];
    if (wr_load || wr_cnt) begin
      cnt_set = 1'b1;
    end else if (run_rise && wr_data[1] && count_q == '0) begin
      cnt_set     = 1'b1;
      cnt_set_val = reload_q;
    end
  end

  tick_timer_div #(.DIV_W(8)) u_div (
    .clk(clk), .rst(rst), .restart(restart), .active(active),
    .div(ctrl_q.div), .tick(tick)
  );

  tick_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .set(cnt_set), .set_val(cnt_set_val),
    .tick(tick), .periodic(ctrl_q.periodic), .reload_val(reload_q),
    .count(count_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_load) reload_q <= wr_data[CNT_W-1:0];
      if (wr_ctrl) ctrl_q <= '{div: wr_data[15:8], periodic: wr_data[1], run: wr_data[0]};
      if (expire) flag_q <= 1'b1;
      else if (wr_flag && wr_data[0]) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q;

  tick_timer_rdmux #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .idx(idx), .reload_val(reload_q),
    .count(count_q), .ctrl(ctrl_q), .flag(flag_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DW-1:0]     wr_data,
  input logic [DW-1:0]     rd_data,
  input logic              irq,
  input logic              enable,
  input logic [DW-1:0]     count
);
  localparam logic [DW-1:0] ONE = DW'(1);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!irq && rd_data == '0));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[ADDR_W-1] == 1'b1) |=> rd_data == '0);

  p_hold_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    (!enable && !wr_en) |=> $stable(count));

  p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && !wr_en && count > ONE) |=> (count == $past(count) || count == $past(count) - ONE));

  p_irq_only_expiry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(count) == ONE && $past(enable)));

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[ADDR_W-1:2] == 3'd3 && wr_data[0] && count != ONE) |=> !irq);
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
  .enable(ctrl_q.run), .count(count_q)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int unsigned vectors = 0, miscompares = 0, cycles = 0;
  bit          done = 1'b0;

  // bench model state
  logic [31:0] m_load, m_cnt, m_exp;
  logic        m_en, m_rl, m_st;
  logic [7:0]  m_div, m_ph;

  always #5 clk = ~clk;

  tick_timer uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                  .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] w);
    case (w)
      3'd0: return m_load;
      3'd1: return m_en ? m_cnt : 32'd0;
      3'd2: return {16'd0, m_div, 6'd0, m_rl, m_en};
      3'd3: return {31'd0, m_st};
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input logic we, input logic re, input logic [4:0] a, input logic [31:0] d);
    logic [2:0] w;
    logic wl, wc, wt, ws, rise, restart, run, tick, expd;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wr_data = d;
    @(posedge clk);
    w = a[4:2];
    wl = we && w == 3'd0; wc = we && w == 3'd1; wt = we && w == 3'd2; ws = we && w == 3'd3;
    if (re) m_exp = model_read(w);
    rise = wt && d[0] && !m_en;
    restart = wl || wc || wt;
    run = m_en && m_cnt != 0 && !restart;
    tick = run && m_ph == m_div;
    expd = tick && m_cnt == 32'd1;
    if (restart || !run || m_ph == m_div) m_ph = 8'd0; else m_ph = m_ph + 8'd1;
    if (wl || wc) m_cnt = d;
    else if (rise && d[1] && m_cnt == 0) m_cnt = m_load;
    else if (tick) m_cnt = (m_cnt == 32'd1) ? (m_rl ? m_load : 32'd0) : m_cnt - 32'd1;
    if (wl) m_load = d;
    if (wt) begin m_div = d[15:8]; m_rl = d[1]; m_en = d[0]; end
    if (expd) m_st = 1'b1; else if (ws && d[0]) m_st = 1'b0;
    #2;
    check("R8 irq vs flag", {31'd0, irq}, {31'd0, m_st});
    if (re) begin
      case (w)
        3'd0: check("R5 reload read", rd_data, m_exp);
        3'd1: check("R10 count read", rd_data, m_exp);
        3'd2: check("R3 control read", rd_data, m_exp);
        3'd3: check("R8 flag read", rd_data, m_exp);
        default: check("R2 unmapped read", rd_data, m_exp);
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'd0, 32'd0);
  endtask

  initial begin
    logic [31:0] held;
    m_load = 0; m_cnt = 0; m_exp = 0; m_en = 0; m_rl = 0; m_st = 0; m_div = 0; m_ph = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 rd_data after reset", rd_data, 32'd0);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 5'(k * 4), 32'd0);
    // R2: writes to unmapped index do nothing, reads give zero
    step(1'b1, 1'b0, 5'h10, 32'hFFFF_FFFF);
    step(1'b1, 1'b0, 5'h1C, 32'hFFFF_FFFF);
    step(1'b0, 1'b1, 5'h14, 32'd0);
    step(1'b0, 1'b1, 5'h08, 32'd0);
    check("R2 control untouched", rd_data, 32'd0);
    // R3: junk bits masked in readback
    step(1'b1, 1'b0, 5'h08, 32'hABCD_5AFC);
    step(1'b0, 1'b1, 5'h08, 32'd0);
    check("R3 control fields", rd_data, 32'h0000_5A00);
    // R5/R4/R6: one-shot, count 4, divider 1 -> irq after 8 cycles
    step(1'b1, 1'b0, 5'h00, 32'd4);
    step(1'b1, 1'b0, 5'h08, 32'h0000_0101);
    idle(7);
    check("R4 no expiry before 8 cycles", {31'd0, irq}, 32'd0);
    idle(1);
    check("R6 expiry after 8 cycles", {31'd0, irq}, 32'd1);
    idle(10);
    step(1'b0, 1'b1, 5'h04, 32'd0);
    check("R6 one-shot stays zero", rd_data, 32'd0);
    // R8: write-one-to-clear
    step(1'b1, 1'b0, 5'h0C, 32'd1);
    check("R8 cleared", {31'd0, irq}, 32'd0);
    idle(20);
    check("R6 no repeat at zero", {31'd0, irq}, 32'd0);
    // R9: enable edge with zero count and periodic pulls reload
    step(1'b1, 1'b0, 5'h08, 32'd0);
    step(1'b1, 1'b0, 5'h08, 32'h0000_0003);
    step(1'b0, 1'b1, 5'h04, 32'd0);
    check("R9 count pulled from reload", rd_data, 32'd4);
    // R7: periodic keeps running
    idle(4);
    step(1'b0, 1'b1, 5'h04, 32'd0);
    check("R7 refilled after expiry", rd_data, m_exp);
    check("R7 flag set by reload", {31'd0, irq}, 32'd1);
    // R10: disabled count reads zero although nonzero
    step(1'b1, 1'b0, 5'h04, 32'd9);
    step(1'b1, 1'b0, 5'h08, 32'd0);
    step(1'b0, 1'b1, 5'h04, 32'd0);
    check("R10 disabled count zero", rd_data, 32'd0);
    // R11: read data holds
    step(1'b0, 1'b1, 5'h00, 32'd0);
    held = rd_data;
    idle(3);
    check("R11 rd_data held", rd_data, held);
    check("R11 held value is reload", held, 32'd4);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [31:0] d;
      logic [4:0] a;
      r = $urandom_range(0, 99);
      a = 5'($urandom_range(0, 31));
      if (r < 55) step(1'b0, 1'b1, a, 32'd0);
      else if (r < 65) step(1'b0, 1'b0, a, 32'd0);
      else begin
        d = $urandom_range(0, 12);
        if (a[4:2] == 3'd2) d = {$urandom_range(0, 65535), 8'($urandom_range(0, 2)), 8'($urandom_range(0, 255))};
        if (a[4:2] == 3'd3) d = $urandom();
        step(1'b1, ($urandom_range(0, 1) == 1), a, d);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule